// File: doc/BRIEF.md
# Reset and Boot Mode Sequencer

This block brings a processor core out of master reset and into execution. While the system reset input is high it keeps the core stopped and drives three clear strobes: one that masks the interrupt controller, one that empties the stack pointers and one that zeroes the mode status register. On a cold start, marked by the power-on input, it also enforces a minimum clock-stabilisation interval before any boot activity. A warm flag, set once the block has passed through the sampling state, lets later reset pulses skip that interval.

When system reset is released, the block captures four configuration pins. These pins are reused as general-purpose flags later, so they are read once only. The captured value selects the memory mode (full or host), whether the acknowledge pin is open-drain, and one of three boot methods. With no boot, the core starts at once from external location 0. With a byte-memory boot, the block pulses a start strobe to a DMA engine and counts a fixed number of loaded program words before it lets the core run. With a host boot, the block waits for a host write to program address 0. After either boot the core starts from on-chip address 0. A pending bus request holds the sequencer in its sampling state until the request is withdrawn.

Top module: `rbs_boot_sequencer`

## Requirements
- R1: While the sequencer sits in its reset state, `clr_irq_mask`, `clr_stack_ptrs` and `clr_status` are 1, and `core_run`, `boot_dma_start`, `full_mem_mode`, `host_mode` and `ack_open_drain` are 0.
- R2: After `por`, the clock edges spent in reset plus stabilisation total at least `STAB_CYCLES`. If `sys_rst` is held for H edges after `por` falls and then released, a no-boot start raises `core_run` max(1, STAB_CYCLES-H)+1 edges after the release edge is counted as the first.
- R3: Once the sampling state has been reached, any later `sys_rst` pulse skips stabilisation, so a no-boot start raises `core_run` 2 edges after release, whatever the pulse length.
- R4: `mode_pins` (bit 3 = D, bit 2 = C, bit 1 = B, bit 0 = A) are captured on the release edge. `host_mode` = C, `full_mem_mode` = not C and `ack_open_drain` = D from the next cycle on. Pin changes after capture have no effect until the next reset.
- R5: C,B,A = 010, and every code that R6 and R7 do not list, selects no boot. One edge after sampling, `core_run` = 1, `start_external` = 1 and `start_addr` = 0.
- R6: C,B,A = 000 or 100 selects a byte-memory boot. `boot_dma_start` is high for exactly one cycle after sampling. `core_run` rises on the edge that sees the `BOOT_WORDS`-th `boot_word_done`, with `start_external` = 0.
- R7: C,B,A = 101 selects a host boot. `core_run` rises on the edge that sees `host_wr` with `host_addr` = 0, with `start_external` = 0. Writes to any other address do not start the core.
- R8: While `bus_req` is 1 in the sampling state, the sequencer stays there, with `core_run` and `boot_dma_start` at 0.
- R9: `boot_word_done` has no effect during a host boot, and `host_wr` has no effect during a byte-memory boot.
- R10: A `sys_rst` edge in any state returns the sequencer to its reset state, and `core_run` falls on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears the warm flag |
| sys_rst | input | 1 | System reset pin, active high |
| mode_pins | input | 4 | Configuration pins D,C,B,A (bits 3..0) |
| bus_req | input | 1 | External bus request; stalls the boot start |
| boot_word_done | input | 1 | One pulse per program word loaded by the byte DMA |
| host_wr | input | 1 | Host write strobe into program memory |
| host_addr | input | ADDR_W | Host write address |
| core_run | output | 1 | Core execution enable |
| start_addr | output | ADDR_W | First fetch address |
| start_external | output | 1 | First fetch comes from external memory |
| full_mem_mode | output | 1 | Full memory mode selected |
| host_mode | output | 1 | Host mode selected |
| ack_open_drain | output | 1 | Acknowledge pin is open-drain |
| boot_dma_start | output | 1 | One-cycle start strobe to the byte DMA |
| clr_irq_mask | output | 1 | Mask all interrupts |
| clr_stack_ptrs | output | 1 | Set the stack pointers to empty |
| clr_status | output | 1 | Clear the mode status register |

## Verification
On every cycle, the assertions check that the reset state keeps the core quiet, that a reset edge always lands in the reset state, that a bus request freezes the sampling state, that the DMA start is a single-cycle pulse, that the captured mode flags stay stable between resets, and that a running core keeps running. Some behaviours can only be shown by the bench's scenarios: the exact start latency for cold and warm resets across a range of reset lengths, the decode of all sixteen pin codes into boot method and flags, and the point at which each boot completes. The scenarios also show that strobes of the wrong kind and writes to non-zero addresses leave the core stopped.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int PIN_A = 0;
    localparam int PIN_B = 1;
    localparam int PIN_C = 2;
    localparam int PIN_D = 3;

    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_STAB     = 3'd1,
        ST_SAMPLE   = 3'd2,
        ST_BOOTWAIT = 3'd3,
        ST_RUN      = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        BM_NONE = 2'd0,
        BM_BYTE = 2'd1,
        BM_HOST = 2'd2
    } boot_method_e;

    typedef struct packed {
        boot_method_e method;
        logic         host_mode;
        logic         ack_od;
    } boot_cfg_t;

    function automatic boot_cfg_t decode_mode(input logic [3:0] pins);
        boot_cfg_t c;
        logic [2:0] cba;
        cba = {pins[PIN_C], pins[PIN_B], pins[PIN_A]};
        case (cba)
            3'b000:  c.method = BM_BYTE;
            3'b100:  c.method = BM_BYTE;
            3'b101:  c.method = BM_HOST;
            default: c.method = BM_NONE;
        endcase
        c.host_mode = pins[PIN_C];
        c.ack_od    = pins[PIN_D];
        return c;
    endfunction

endpackage

// File: rtl/rbs_stab_timer.sv
module rbs_stab_timer #(
    parameter int LIMIT = 2000,
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic por,
    input  logic clear,
    input  logic en,
    output logic near_done
);
    localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] NEAR_C = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (por || clear) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != LIM_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign near_done = (cnt_q >= NEAR_C);
endmodule

// File: rtl/rbs_word_counter.sv
module rbs_word_counter #(
    parameter int WORDS = 32
) (
    input  logic clk,
    input  logic por,
    input  logic clear,
    input  logic inc,
    output logic last
);
    localparam int WC_W = $clog2(WORDS + 1);
    localparam logic [WC_W-1:0] LAST_C = WC_W'(WORDS - 1);

    logic [WC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (por || clear) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_C);
endmodule

// File: rtl/rbs_mode_latch.sv
module rbs_mode_latch
    import rbs_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       clear,
    input  logic       load,
    input  logic [3:0] pins,
    output boot_cfg_t  cfg,
    output logic       valid
);
    boot_cfg_t cfg_q;
    logic      valid_q;

    always_ff @(posedge clk) begin
        if (por || clear) begin
            cfg_q   <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            cfg_q   <= decode_mode(pins);
            valid_q <= 1'b1;
        end
    end

    assign cfg   = cfg_q;
    assign valid = valid_q;
endmodule

// File: rtl/rbs_boot_sequencer.sv
module rbs_boot_sequencer
    import rbs_pkg::*;
#(
    parameter int STAB_CYCLES = 2000,
    parameter int CNT_W       = 12,
    parameter int BOOT_WORDS  = 32,
    parameter int ADDR_W      = 14,
    parameter int START_ADDR  = 0
) (
    input  logic              clk,
    input  logic              por,
    input  logic              sys_rst,
    input  logic [3:0]        mode_pins,
    input  logic              bus_req,
    input  logic              boot_word_done,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              core_run,
    output logic [ADDR_W-1:0] start_addr,
    output logic              start_external,
    output logic              full_mem_mode,
    output logic              host_mode,
    output logic              ack_open_drain,
    output logic              boot_dma_start,
    output logic              clr_irq_mask,
    output logic              clr_stack_ptrs,
    output logic              clr_status
);
    localparam logic [ADDR_W-1:0] START_C = ADDR_W'(START_ADDR);

    seq_state_e state_q, state_d;
    logic       warm_q;
    logic       dma_q;
    logic       ext_q;

    boot_cfg_t  cfg;
    logic       cfg_valid;
    logic       tmr_near;
    logic       wc_last;

    logic       tmr_clear, tmr_en;
    logic       wc_clear, wc_inc;
    logic       latch_load;
    logic       host_hit;
    logic       leave_sample;

    assign tmr_clear  = sys_rst && (state_q != ST_RESET);
    assign tmr_en     = (state_q == ST_RESET) || (state_q == ST_STAB);
    assign wc_clear   = (state_q != ST_BOOTWAIT);
    assign wc_inc     = (state_q == ST_BOOTWAIT) && (cfg.method == BM_BYTE) && boot_word_done;
    assign latch_load = (state_q == ST_RESET) && !sys_rst;
    assign host_hit   = host_wr && (host_addr == '0);
    assign leave_sample = (state_q == ST_SAMPLE) && !bus_req && !sys_rst;

    rbs_stab_timer #(.LIMIT(STAB_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .por      (por),
        .clear    (tmr_clear),
        .en       (tmr_en),
        .near_done(tmr_near)
    );

    rbs_word_counter #(.WORDS(BOOT_WORDS)) u_words (
        .clk  (clk),
        .por  (por),
        .clear(wc_clear),
        .inc  (wc_inc),
        .last (wc_last)
    );

    rbs_mode_latch u_latch (
        .clk  (clk),
        .por  (por),
        .clear(sys_rst),
        .load (latch_load),
        .pins (mode_pins),
        .cfg  (cfg),
        .valid(cfg_valid)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET: begin
                if (warm_q || tmr_near) state_d = ST_SAMPLE;
                else                    state_d = ST_STAB;
            end
            ST_STAB: begin
                if (tmr_near) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (!bus_req) begin
                    if (cfg.method == BM_NONE) state_d = ST_RUN;
                    else                       state_d = ST_BOOTWAIT;
                end
            end
            ST_BOOTWAIT: begin
                if (cfg.method == BM_BYTE) begin
                    if (boot_word_done && wc_last) state_d = ST_RUN;
                end else if (cfg.method == BM_HOST) begin
                    if (host_hit) state_d = ST_RUN;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_RESET;
        endcase
        if (sys_rst) state_d = ST_RESET;
    end

    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= ST_RESET;
            warm_q  <= 1'b0;
            dma_q   <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SAMPLE) warm_q <= 1'b1;
            dma_q <= leave_sample && (cfg.method == BM_BYTE);
            if (sys_rst)                                 ext_q <= 1'b0;
            else if (leave_sample)                       ext_q <= (cfg.method == BM_NONE);
        end
    end

    assign core_run       = (state_q == ST_RUN);
    assign start_addr     = START_C;
    assign start_external = ext_q;
    assign full_mem_mode  = cfg_valid && !cfg.host_mode;
    assign host_mode      = cfg_valid && cfg.host_mode;
    assign ack_open_drain = cfg_valid && cfg.ack_od;
    assign boot_dma_start = dma_q;
    assign clr_irq_mask   = (state_q == ST_RESET);
    assign clr_stack_ptrs = (state_q == ST_RESET);
    assign clr_status     = (state_q == ST_RESET);
endmodule

// File: rtl/rbs_boot_sequencer_chk.sv
module rbs_boot_sequencer_chk
    import rbs_pkg::*;
(
    input logic       clk,
    input logic       por,
    input logic       sys_rst,
    input logic       bus_req,
    input seq_state_e state,
    input logic       core_run,
    input logic       boot_dma_start,
    input logic       full_mem_mode,
    input logic       host_mode,
    input logic       ack_open_drain,
    input logic       clr_stack_ptrs
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (por)
        clr_stack_ptrs |-> (!core_run && !boot_dma_start));

    p_rst_entry_r10: assert property (@(posedge clk) disable iff (por)
        sys_rst |=> (state == ST_RESET && !core_run));

    p_bus_stall_r8: assert property (@(posedge clk) disable iff (por)
        (state == ST_SAMPLE && bus_req && !sys_rst) |=> (state == ST_SAMPLE && !boot_dma_start));

    p_dma_pulse_r6: assert property (@(posedge clk) disable iff (por)
        boot_dma_start |=> !boot_dma_start);

    p_mode_excl_r4: assert property (@(posedge clk) disable iff (por)
        !(full_mem_mode && host_mode));

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (por)
        (!sys_rst && state != ST_RESET) |=> $stable({full_mem_mode, host_mode, ack_open_drain}));

    p_run_hold_r5: assert property (@(posedge clk) disable iff (por)
        (core_run && !sys_rst) |=> core_run);
endmodule

bind rbs_boot_sequencer rbs_boot_sequencer_chk u_chk (
    .clk           (clk),
    .por           (por),
    .sys_rst       (sys_rst),
    .bus_req       (bus_req),
    .state         (state_q),
    .core_run      (core_run),
    .boot_dma_start(boot_dma_start),
    .full_mem_mode (full_mem_mode),
    .host_mode     (host_mode),
    .ack_open_drain(ack_open_drain),
    .clr_stack_ptrs(clr_stack_ptrs)
);

// File: tb/sim_rbs_boot_sequencer.sv
`timescale 1ns/1ps
module sim_rbs_boot_sequencer;
    localparam int STAB  = 24;
    localparam int WORDS = 6;
    localparam int AW    = 8;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic sys_rst = 1'b1;
    logic [3:0] mode_pins = 4'b0010;
    logic bus_req = 1'b0;
    logic boot_word_done = 1'b0;
    logic host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;

    logic core_run, start_external, full_mem_mode, host_mode, ack_open_drain;
    logic boot_dma_start, clr_irq_mask, clr_stack_ptrs, clr_status;
    logic [AW-1:0] start_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rbs_boot_sequencer #(.STAB_CYCLES(STAB), .CNT_W(12), .BOOT_WORDS(WORDS), .ADDR_W(AW)) u0 (
        .clk(clk), .por(por), .sys_rst(sys_rst), .mode_pins(mode_pins), .bus_req(bus_req),
        .boot_word_done(boot_word_done), .host_wr(host_wr), .host_addr(host_addr),
        .core_run(core_run), .start_addr(start_addr), .start_external(start_external),
        .full_mem_mode(full_mem_mode), .host_mode(host_mode), .ack_open_drain(ack_open_drain),
        .boot_dma_start(boot_dma_start), .clr_irq_mask(clr_irq_mask),
        .clr_stack_ptrs(clr_stack_ptrs), .clr_status(clr_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cold_start();
        por = 1'b1; sys_rst = 1'b1;
        repeat (3) step();
        por = 1'b0;
    endtask

    task automatic release_measure(output int n);
        sys_rst = 1'b0;
        n = 0;
        do begin
            step();
            n++;
        end while (!core_run && n < 200);
    endtask

    task automatic check_reset_state(input string req);
        chk({req, " clr_irq_mask"}, int'(clr_irq_mask), 1);
        chk({req, " clr_stack_ptrs"}, int'(clr_stack_ptrs), 1);
        chk({req, " clr_status"}, int'(clr_status), 1);
        chk({req, " core_run"}, int'(core_run), 0);
        chk({req, " dma"}, int'(boot_dma_start), 0);
        chk({req, " flags"}, int'({full_mem_mode, host_mode, ack_open_drain}), 0);
    endtask

    task automatic word_strobe();
        boot_word_done = 1'b1; step(); boot_word_done = 1'b0;
    endtask

    task automatic host_write(input logic [AW-1:0] a);
        host_wr = 1'b1; host_addr = a; step(); host_wr = 1'b0; host_addr = '0;
    endtask

    initial begin
        int n;
        @(negedge clk);
        mode_pins = 4'b0010;

        // R1 and R2: cold starts with a range of reset lengths
        for (int h = 0; h <= STAB + 3; h += 3) begin
            cold_start();
            sys_rst = 1'b1;
            repeat (h) step();
            check_reset_state("R1");
            release_measure(n);
            chk("R2 cold latency", n, ((STAB - h) > 1 ? (STAB - h) : 1) + 1);
        end

        // R3: warm reset skips stabilisation
        for (int h = 1; h <= 9; h += 4) begin
            sys_rst = 1'b1;
            repeat (h) step();
            chk("R10 core_run low after reset edge", int'(core_run), 0);
            release_measure(n);
            chk("R3 warm latency", n, 2);
        end

        // R8: bus request stalls sampling (byte boot code)
        mode_pins = 4'b0000;
        sys_rst = 1'b1; step(); step();
        bus_req = 1'b1;
        sys_rst = 1'b0;
        repeat (6) step();
        chk("R8 core_run stalled", int'(core_run), 0);
        chk("R8 dma stalled", int'(boot_dma_start), 0);
        bus_req = 1'b0;
        step();
        chk("R8 dma after release", int'(boot_dma_start), 1);

        // R4..R7, R9: sweep of all pin codes
        for (int m = 0; m < 16; m++) begin
            logic c, b, a, d;
            int method;
            d = m[3]; c = m[2]; b = m[1]; a = m[0];
            if ({c, b, a} == 3'b000 || {c, b, a} == 3'b100) method = 1;
            else if ({c, b, a} == 3'b101) method = 2;
            else method = 0;

            mode_pins = 4'(m);
            sys_rst = 1'b1; step();
            chk("R10 reset entry core_run", int'(core_run), 0);
            step();
            check_reset_state("R1 sweep");
            sys_rst = 1'b0; step();
            chk("R4 full_mem_mode", int'(full_mem_mode), int'(!c));
            chk("R4 host_mode", int'(host_mode), int'(c));
            chk("R4 ack_open_drain", int'(ack_open_drain), int'(d));
            mode_pins = ~4'(m);
            step();
            chk("R6 dma strobe", int'(boot_dma_start), (method == 1) ? 1 : 0);
            if (method == 0) begin
                chk("R5 core_run", int'(core_run), 1);
                chk("R5 start_external", int'(start_external), 1);
                chk("R5 start_addr", int'(start_addr), 0);
            end else if (method == 1) begin
                chk("R6 core_run held", int'(core_run), 0);
                host_write('0);
                chk("R6 dma one cycle", int'(boot_dma_start), 0);
                chk("R9 host write ignored in byte boot", int'(core_run), 0);
                for (int w = 0; w < WORDS - 1; w++) word_strobe();
                chk("R6 core_run before last word", int'(core_run), 0);
                word_strobe();
                chk("R6 core_run after last word", int'(core_run), 1);
                chk("R6 start_external", int'(start_external), 0);
            end else begin
                for (int w = 0; w < WORDS + 2; w++) word_strobe();
                chk("R9 word strobes ignored in host boot", int'(core_run), 0);
                host_write(8'd3);
                chk("R7 nonzero address ignored", int'(core_run), 0);
                host_write('0);
                chk("R7 core_run after write to 0", int'(core_run), 1);
                chk("R7 start_external", int'(start_external), 0);
            end
            chk("R4 flags held after pin change", int'({full_mem_mode, host_mode, ack_open_drain}),
                int'({!c, c, d}));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule